// File: doc/BRIEF.md
# Debug Memory Write Command Engine

This block sits behind the byte receiver of a debug port. It turns a short packet sequence from the host into a single write on an internal bus master port. The first byte selects the access size and says whether a status byte should come back. Three address bytes and then one, two or four data bytes follow. The engine aligns the address to the access size and places the data on the matching byte lanes. It raises a request, holds it until the bus acknowledges, and can then return one status byte to the host.

The host is expected to stay silent while the engine is busy. Any byte that arrives in that window is discarded and flagged. A first byte that names no known write command is also flagged, and the engine goes back to waiting for a command without touching the bus. The bus type and mode attributes come from a static input and are passed through to the bus unchanged.

Top module: `dbgw_write_engine`

## Requirements
- R1: Command bytes 0x10, 0x14 and 0x18 start a write of 1, 2 and 4 bytes; `bus_size` is then 0, 1 and 2 respectively (byte, 16-bit, 32-bit).
- R2: Command bytes 0x11, 0x15 and 0x19 start the same three writes and also request a status byte after the write.
- R3: After the command, three bytes form the 24-bit address, most significant byte first.
- R4: After the address come the data bytes, most significant first, with as many bytes as the size needs. Lanes are big-endian: bits 31:24 carry byte offset 0 and bits 7:0 carry offset 3. A byte write at offset a sets strobe bit 3-a. A 16-bit write sets strobes 1100 when address bit 1 is 0 and 0011 when it is 1. A 32-bit write sets 1111. Data sits on the strobed lanes and unused lanes read zero.
- R5: `bus_addr` has bit 0 cleared for 16-bit writes and bits 1:0 cleared for 32-bit writes. Byte writes keep the full address.
- R6: `bus_req` rises in the cycle after the last data byte is taken. Address, data, strobes and size stay fixed until the cycle in which `bus_ack` is high.
- R7: For a status write, `tx_valid` is high for exactly one cycle, which is the cycle after the acknowledge. `tx_byte` then equals `stat_byte_i` as it stands in that cycle, so it shows the state after the write.
- R8: `busy` is high from the cycle after the last data byte until the status cycle ends, or until the acknowledge for writes without status. Writes without status never raise `tx_valid`.
- R9: `bus_attr` equals `attr_i`.
- R10: A command byte outside the six above makes `cmd_err` high for one cycle, in the cycle after that byte. There is no bus request, and the next byte is decoded as a new command.
- R11: A byte received while `busy` is high is discarded. `overrun` is high for one cycle, in the cycle after that byte, and the pending write is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Host byte present this cycle |
| rx_byte | input | 8 | Host byte |
| attr_i | input | ATTR_W | Static bus type/mode attributes |
| stat_byte_i | input | 8 | Core status byte (top byte of the extended status register) |
| tx_valid | output | 1 | Status byte to host is valid |
| tx_byte | output | 8 | Status byte to host |
| busy | output | 1 | Write in progress; host must not send |
| cmd_err | output | 1 | Illegal command pulse |
| overrun | output | 1 | Byte dropped while busy pulse |
| bus_req | output | 1 | Bus write request |
| bus_ack | input | 1 | Bus write complete |
| bus_addr | output | ADDR_W | Aligned write address |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_strb | output | 4 | Byte-lane strobes, bit i covers bits 8i+7:8i |
| bus_size | output | 2 | 0 byte, 1 16-bit, 2 32-bit |
| bus_attr | output | ATTR_W | Attributes passed through |

## Verification
The bench sweeps every size, both status options and all four low address offsets, using two address and data patterns. This catches a lane swap or an off-by-one in the alignment mask, which would show up as wrong strobes or as data on the mirrored lane. It sends every one of the 250 illegal command bytes. A decoder that ignored bit 1 or accepted size code 3 would start a bus write or stay out of idle. Varied acknowledge delays and bytes injected while busy expose an engine that drops the request early, treats a dropped byte as the next command, or returns status from before the write.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } wsize_e;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_ADDR,
      PS_DATA,
      PS_BUS,
      PS_STAT
   } pstate_e;

   // legal write commands: 0001_ss0w with ss in {00,01,10}
   function automatic logic cmd_legal(input logic [7:0] c);
      return (c[7:4] == 4'h1) && (c[1] == 1'b0) && (c[3:2] != 2'b11);
   endfunction

   // low-bit mask of an access: bytes - 1
   function automatic logic [1:0] size_mask(input wsize_e s);
      case (s)
         SZ_HALF: return 2'b01;
         SZ_WORD: return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/dbgw_parse.sv
module dbgw_parse
   import dbgw_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              bus_ack,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output wsize_e            size_q,
   output logic              in_bus,
   output logic              in_stat,
   output logic              err_q,
   output logic              ovr_q
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int MAX_CNT    = (ADDR_BYTES > 4) ? ADDR_BYTES : 4;
   localparam int CNT_W      = $clog2(MAX_CNT);

   pstate_e          st;
   logic             ws_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] data_last;

   assign data_last = CNT_W'(size_mask(size_q));
   assign in_bus    = (st == PS_BUS);
   assign in_stat   = (st == PS_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= PS_IDLE;
         ws_q   <= 1'b0;
         cnt    <= '0;
         addr_q <= '0;
         data_q <= '0;
         size_q <= SZ_BYTE;
         err_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         ovr_q <= 1'b0;
         case (st)
            PS_IDLE: if (rx_valid) begin
               if (cmd_legal(rx_byte)) begin
                  size_q <= wsize_e'(rx_byte[3:2]);
                  ws_q   <= rx_byte[0];
                  cnt    <= '0;
                  data_q <= '0;
                  st     <= PS_ADDR;
               end else begin
                  err_q  <= 1'b1;
               end
            end
            PS_ADDR: if (rx_valid) begin
               addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
               if (cnt == CNT_W'(ADDR_BYTES - 1)) begin
                  cnt <= '0;
                  st  <= PS_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PS_DATA: if (rx_valid) begin
               data_q <= {data_q[DATA_W-9:0], rx_byte};
               if (cnt == data_last) st <= PS_BUS;
               else                  cnt <= cnt + 1'b1;
            end
            PS_BUS: begin
               if (rx_valid) ovr_q <= 1'b1;
               if (bus_ack)  st <= ws_q ? PS_STAT : PS_IDLE;
            end
            PS_STAT: begin
               if (rx_valid) ovr_q <= 1'b1;
               st <= PS_IDLE;
            end
            default: st <= PS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dbgw_lanes.sv
module dbgw_lanes
   import dbgw_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0] addr_raw,
   input  wsize_e            size,
   input  logic [DATA_W-1:0] data,
   output logic [ADDR_W-1:0] addr_al,
   output logic [DATA_W-1:0] wdata,
   output logic [3:0]        strb
);
   localparam int LANES = DATA_W / 8;

   logic [1:0] nmask;
   logic [1:0] base;

   assign nmask   = size_mask(size);
   assign base    = addr_raw[1:0] & ~nmask;
   assign addr_al = {addr_raw[ADDR_W-1:2], base};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // big-endian: lane i holds byte offset LANES-1-i
      localparam logic [1:0] OFF = 2'(LANES - 1 - i);
      logic [1:0] sel;
      logic       on;
      assign on  = ((OFF & ~nmask) == base);
      assign sel = nmask - (OFF - base);
      assign strb[i]        = on;
      assign wdata[8*i +: 8] = on ? data[{sel, 3'b000} +: 8] : 8'h00;
   end
endmodule

// File: rtl/dbgw_write_engine.sv
module dbgw_write_engine
   import dbgw_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   parameter int ATTR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic [ATTR_W-1:0] attr_i,
   input  logic [7:0]        stat_byte_i,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   output logic              busy,
   output logic              cmd_err,
   output logic              overrun,
   output logic              bus_req,
   input  logic              bus_ack,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [3:0]        bus_strb,
   output logic [1:0]        bus_size,
   output logic [ATTR_W-1:0] bus_attr
);
   if (ADDR_W % 8 != 0 || ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
      $error("dbgw_write_engine: ADDR_W must be 16..32 and a multiple of 8");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("dbgw_write_engine: DATA_W must be 32");
   end
   if (ATTR_W < 1) begin : g_bad_attr
      $error("dbgw_write_engine: ATTR_W must be positive");
   end

   logic [ADDR_W-1:0] addr_raw;
   logic [DATA_W-1:0] data_raw;
   wsize_e            size_q;
   logic              in_bus;
   logic              in_stat;

   dbgw_parse #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parse (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .bus_ack  (bus_ack),
      .addr_q   (addr_raw),
      .data_q   (data_raw),
      .size_q   (size_q),
      .in_bus   (in_bus),
      .in_stat  (in_stat),
      .err_q    (cmd_err),
      .ovr_q    (overrun)
   );

   dbgw_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
      .addr_raw (addr_raw),
      .size     (size_q),
      .data     (data_raw),
      .addr_al  (bus_addr),
      .wdata    (bus_wdata),
      .strb     (bus_strb)
   );

   assign bus_req  = in_bus;
   assign bus_size = size_q;
   assign bus_attr = attr_i;
   assign busy     = in_bus | in_stat;
   assign tx_valid = in_stat;
   assign tx_byte  = in_stat ? stat_byte_i : 8'h00;
endmodule

// File: rtl/dbgw_write_engine_chk.sv
module dbgw_write_engine_chk #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [3:0]        bus_strb,
   input logic [1:0]        bus_size,
   input logic              busy,
   input logic              tx_valid,
   input logic              cmd_err,
   input logic              overrun
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata)
                              && $stable(bus_strb) && $stable(bus_size)); // R6
   AST_ALIGN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_size == 2'd1 |-> bus_addr[0] == 1'b0); // R5
   AST_ALIGN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_size == 2'd2 |-> bus_addr[1:0] == 2'b00); // R5
   AST_STRB_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> $countones(bus_strb) == (1 << bus_size)); // R4
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> busy); // R8
   AST_TX_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(bus_req && bus_ack)); // R7
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> !bus_req && !busy); // R10
   AST_OVR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(busy)); // R11
endmodule

bind dbgw_write_engine dbgw_write_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dbgw_write_engine.sv
module tb_dbgw_write_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [2:0]  attr_i = 3'b101;
   logic [7:0]  stat_byte_i = 8'h00;
   logic        tx_valid, busy, cmd_err, overrun, bus_req;
   logic [7:0]  tx_byte;
   logic        bus_ack = 1'b0;
   logic [23:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [3:0]  bus_strb;
   logic [1:0]  bus_size;
   logic [2:0]  bus_attr;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dbgw_write_engine dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .attr_i(attr_i), .stat_byte_i(stat_byte_i), .tx_valid(tx_valid),
      .tx_byte(tx_byte), .busy(busy), .cmd_err(cmd_err), .overrun(overrun),
      .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_size(bus_size),
      .bus_attr(bus_attr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // starts and ends at a negedge
   task automatic send_byte(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic txn(input int sz, input int ws, input logic [23:0] addr,
                      input logic [31:0] data, input int waits, input bit ovr);
      int n, shift;
      logic [31:0] dmask, exp_w;
      logic [3:0]  exp_s;
      logic [23:0] exp_a;
      logic [7:0]  new_stat;
      n     = 1 << sz;
      dmask = (n == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * n)) - 1);
      shift = 4 - n - (int'(addr[1:0]) & ~(n - 1) & 3);
      exp_w = (data & dmask) << (8 * shift);
      exp_s = 4'(((1 << n) - 1) << shift);
      exp_a = addr & ~24'(n - 1);
      send_byte(8'h10 | 8'(sz << 2) | 8'(ws));
      send_byte(addr[23:16]);
      send_byte(addr[15:8]);
      send_byte(addr[7:0]);
      for (int j = 0; j < n; j++) begin
         chk("R6 no request during data phase", 32'(bus_req), 32'd0);
         send_byte(data[8 * (n - 1 - j) +: 8]);
      end
      chk("R6 request raised", 32'(bus_req), 32'd1);
      chk("R1 size code", 32'(bus_size), 32'(sz));
      chk("R3/R5 address", 32'(bus_addr), 32'(exp_a));
      chk("R4 lane data", bus_wdata, exp_w);
      chk("R4 strobes", 32'(bus_strb), 32'(exp_s));
      chk("R9 attributes", 32'(bus_attr), 32'(attr_i));
      chk("R8 busy at request", 32'(busy), 32'd1);
      for (int w = 0; w < waits; w++) begin
         if (ovr && w == 0) begin
            send_byte(8'h18);
            chk("R11 overrun pulse", 32'(overrun), 32'd1);
         end else begin
            @(negedge clk);
         end
         chk("R6 request held", 32'(bus_req), 32'd1);
         chk("R6 address held", 32'(bus_addr), 32'(exp_a));
         chk("R6 data held", bus_wdata, exp_w);
      end
      new_stat    = 8'(data[7:0] ^ 8'h5C ^ 8'(sz * 16 + ws));
      stat_byte_i = new_stat;
      bus_ack     = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
      chk("R6 request dropped after ack", 32'(bus_req), 32'd0);
      if (ws != 0) begin
         chk("R2 status returned", 32'(tx_valid), 32'd1);
         chk("R7 status value after write", 32'(tx_byte), 32'(new_stat));
         chk("R8 busy through status", 32'(busy), 32'd1);
         stat_byte_i = ~new_stat;
         @(negedge clk);
         chk("R7 single status cycle", 32'(tx_valid), 32'd0);
         chk("R8 idle after status", 32'(busy), 32'd0);
      end else begin
         chk("R8 no status for plain write", 32'(tx_valid), 32'd0);
         chk("R8 idle after ack", 32'(busy), 32'd0);
         @(negedge clk);
         chk("R8 still no status", 32'(tx_valid), 32'd0);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [23:0] a;
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 reset request low", 32'(bus_req), 32'd0);
      chk("R8 reset not busy", 32'(busy), 32'd0);
      chk("R7 reset no status", 32'(tx_valid), 32'd0);
      chk("R10 reset no error", 32'(cmd_err), 32'd0);
      chk("R11 reset no overrun", 32'(overrun), 32'd0);

      for (int sz = 0; sz < 3; sz++)
         for (int ws = 0; ws < 2; ws++)
            for (int off = 0; off < 4; off++)
               for (int pat = 0; pat < 2; pat++) begin
                  a = (pat != 0 ? 24'hC35AF0 : 24'h123450) | 24'(off);
                  d = (pat != 0) ? 32'h1357_9BDF : 32'h89AB_CDEF;
                  attr_i = 3'(sz * 2 + ws + pat);
                  txn(sz, ws, a, d, 1 + (pat + off) % 3, off == 2);
               end

      // every illegal command byte
      for (int c = 0; c < 256; c++) begin
         if (!((c >> 4) == 1 && (c & 2) == 0 && ((c >> 2) & 3) != 3)) begin
            send_byte(8'(c));
            chk("R10 error pulse", 32'(cmd_err), 32'd1);
            chk("R10 no bus request", 32'(bus_req), 32'd0);
            chk("R10 not busy", 32'(busy), 32'd0);
            @(negedge clk);
            chk("R10 pulse one cycle", 32'(cmd_err), 32'd0);
         end
      end
      // parser back in idle: a legal write follows directly
      txn(2, 1, 24'hFFFFFF, 32'hDEAD_BEEF, 2, 1'b1);
      txn(0, 0, 24'h000003, 32'h0000_0077, 1, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule